// File: doc/BRIEF.md
# DRAM Bank Request Engine

This block is one request tracker out of a pool of identical trackers inside a DRAM controller. When the pool hands it a request, it latches the rank, bank, row, column and direction. It stays bound to that bank until the request is retired. While bound, it raises the row and column commands the request needs toward an external command arbiter and waits for each grant. It holds back those commands while rank or data-bus timing trackers forbid them. It also holds them back until its own activate-to-column and recovery windows have run out.

Consecutive requests to the same bank avoid row overhead. The pool tells the engine, at acceptance, that the previous tracker left the wanted row open. The engine then goes straight to its column command. After the column command, the engine checks whether another queued request targets the same bank. If one does, it releases without precharging and flags that the row is still open. Otherwise it precharges as soon as recovery allows, waits out the precharge time, and returns to the idle pool.

Top module: `bank_req_engine`

## Requirements
- R1: After reset `free` is 1, `left_open` is 0 and no command request is raised. A request is taken only when `req_valid` is seen while `free` is 1, and `free` is 0 from the next cycle on. A `req_valid` that arrives while busy is ignored.
- R2: For a request without an inherited open row and without a pending same-bank request, the activate request comes first, then the column request, then the precharge request, then `free`.
- R3: After an activate grant in cycle G, `cas_req` is raised no earlier than cycle G+T_RCD. With no other hold-off, it is raised exactly in that cycle.
- R4: `act_req` is low while the bit of `rank_inhibit` indexed by the request's rank is 1. Bits of other ranks have no effect.
- R5: `cas_req` is low while `col_inhibit` is 1 or `cas_ok` is 0.
- R6: A request accepted with `req_row_open`=1 raises no activate, and it raises `cas_req` in the first cycle after acceptance when nothing holds it off.
- R7: If `same_bank_pending` is 1 when recovery expires, no precharge is requested. `free` returns one cycle later, and `left_open` is 1 until the next acceptance. Otherwise `left_open` stays 0.
- R8: After a column grant in cycle C, `pre_req` is raised exactly in cycle C+T_WR for a write (`req_write`=1) or in cycle C+T_RTP for a read, given an immediate decision to close.
- R9: After a precharge grant in cycle P, `free` returns in cycle P+T_RP+1.
- R10: Every request receives exactly one column grant, and `cas_req` drops in the cycle after its grant.
- R11: While busy, the command fields `cmd_rank`, `cmd_bank`, `cmd_row`, `cmd_col` and `cmd_write` hold the accepted request's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pool offers a request |
| req_rank | input | RANK_W | Target rank |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row_open | input | 1 | Previous tracker left this row open; skip activate |
| same_bank_pending | input | 1 | A queued request targets the same bank |
| rank_inhibit | input | RANKS | Per-rank activate hold-off |
| col_inhibit | input | 1 | Data bus not available |
| cas_ok | input | 1 | Priority and ordering allow the column command |
| free | output | 1 | Engine is in the idle pool |
| act_req | output | 1 | Activate request |
| act_grant | input | 1 | Activate granted |
| cas_req | output | 1 | Column command request |
| cas_grant | input | 1 | Column command granted |
| pre_req | output | 1 | Precharge request |
| pre_grant | input | 1 | Precharge granted |
| cmd_rank | output | RANK_W | Bound rank |
| cmd_bank | output | BANK_W | Bound bank |
| cmd_row | output | ROW_W | Bound row |
| cmd_col | output | COL_W | Bound column |
| cmd_write | output | 1 | Bound direction |
| left_open | output | 1 | Last release left the row open |

## Verification
Every cycle, the checker enforces the following:
- the gating of activate by its own rank's inhibit and of the column request by bus inhibit and ordering clearance;
- the lower bounds of the activate-to-column and recovery windows;
- the single column grant per request;
- the hold of the bound fields while busy.

Only the bench's scenarios show some properties:
- the exact cycles at which each request appears when the arbiter answers late;
- the full activate, column, precharge, release ordering;
- the skipped activate and skipped precharge under inheritance;
- the exact release cycle after precharge.

// File: rtl/bank_req_engine.sv
module bank_req_engine #(
  parameter int RANKS  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 4,
  parameter int T_RTP  = 2,
  parameter int T_RP   = 3,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_row_open,
  input  logic              same_bank_pending,
  input  logic [RANKS-1:0]  rank_inhibit,
  input  logic              col_inhibit,
  input  logic              cas_ok,
  output logic              free,
  output logic              act_req,
  input  logic              act_grant,
  output logic              cas_req,
  input  logic              cas_grant,
  output logic              pre_req,
  input  logic              pre_grant,
  output logic [RANK_W-1:0] cmd_rank,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_write,
  output logic              left_open
);
  localparam int M1   = (T_RCD > T_WR) ? T_RCD : T_WR;
  localparam int M2   = (T_RTP > T_RP) ? T_RTP : T_RP;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_CAS, S_CLOSE, S_PREW} st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic tmr_zero;

  assign tmr_zero = (tmr == '0);
  assign free     = (st == S_IDLE);
  assign act_req  = (st == S_ACT) && !rank_inhibit[cmd_rank];
  assign cas_req  = (st == S_CAS) && tmr_zero && !col_inhibit && cas_ok;
  assign pre_req  = (st == S_CLOSE) && tmr_zero && !same_bank_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      left_open <= 1'b0;
      cmd_rank  <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_write <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cmd_rank  <= req_rank;
          cmd_bank  <= req_bank;
          cmd_row   <= req_row;
          cmd_col   <= req_col;
          cmd_write <= req_write;
          left_open <= 1'b0;
          tmr       <= '0;
          st        <= req_row_open ? S_CAS : S_ACT;
        end
        S_ACT: if (act_req && act_grant) begin
          tmr <= TW'(T_RCD - 1);
          st  <= S_CAS;
        end
        S_CAS: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (cas_req && cas_grant) begin
            tmr <= cmd_write ? TW'(T_WR - 1) : TW'(T_RTP - 1);
            st  <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (same_bank_pending) begin
            left_open <= 1'b1;
            st        <= S_IDLE;
          end else if (pre_grant) begin
            tmr <= TW'(T_RP - 1);
            st  <= S_PREW;
          end
        end
        S_PREW: begin
          if (!tmr_zero) tmr <= tmr - 1'b1;
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_req_engine_chk.sv
module bank_req_engine_chk #(
  parameter int RANKS  = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 4,
  parameter int T_RTP  = 2,
  parameter int T_RP   = 3,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [RANK_W-1:0] req_rank,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [COL_W-1:0]  req_col,
  input logic              req_write,
  input logic              req_row_open,
  input logic              same_bank_pending,
  input logic [RANKS-1:0]  rank_inhibit,
  input logic              col_inhibit,
  input logic              cas_ok,
  input logic              free,
  input logic              act_req,
  input logic              act_grant,
  input logic              cas_req,
  input logic              cas_grant,
  input logic              pre_req,
  input logic              pre_grant,
  input logic [RANK_W-1:0] cmd_rank,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic              cmd_write,
  input logic              left_open
);
  logic [15:0] since_act, since_cas;
  logic        had_act, inh, last_wr;
  logic [1:0]  cas_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0; since_cas <= '0;
      had_act <= 1'b0; inh <= 1'b0; last_wr <= 1'b0; cas_cnt <= '0;
    end else begin
      since_act <= (since_act == 16'hFFFF) ? since_act : since_act + 16'd1;
      since_cas <= (since_cas == 16'hFFFF) ? since_cas : since_cas + 16'd1;
      if (free && req_valid) begin
        had_act <= 1'b0; inh <= req_row_open; cas_cnt <= '0;
      end
      if (act_req && act_grant) begin
        had_act <= 1'b1; since_act <= 16'd1;
      end
      if (cas_req && cas_grant) begin
        cas_cnt <= cas_cnt + 2'd1; since_cas <= 16'd1; last_wr <= cmd_write;
      end
    end
  end

  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    free && req_valid |=> !free);  // R1
  AST_ACT_RANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> !rank_inhibit[cmd_rank]);  // R4
  AST_CAS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cas_req |-> (!col_inhibit && cas_ok));  // R5
  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    cas_req && had_act |-> since_act >= 16'(T_RCD));  // R3
  AST_INHERIT_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    !free && inh |-> !act_req);  // R6
  AST_CAS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_req |-> cas_cnt == 2'd0);  // R10
  AST_CAS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_req && cas_grant |=> !cas_req);  // R10
  AST_PRE_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> cas_cnt == 2'd1);  // R2
  AST_PRE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> since_cas >= (last_wr ? 16'(T_WR) : 16'(T_RTP)));  // R8
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !free |=> (free || $stable({cmd_rank, cmd_bank, cmd_row, cmd_col, cmd_write})));  // R11
endmodule

bind bank_req_engine bank_req_engine_chk #(
  .RANKS(RANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
  .T_RCD(T_RCD), .T_WR(T_WR), .T_RTP(T_RTP), .T_RP(T_RP)
) u_chk (.*);

// File: tb/test_bank_req_engine.sv
module test_bank_req_engine;
  localparam int T_RCD = 3, T_WR = 4, T_RTP = 2, T_RP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_row_open = 0, same_bank_pending = 0;
  logic [0:0] req_rank = '0;
  logic [2:0] req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [1:0] rank_inhibit = '0;
  logic col_inhibit = 0, cas_ok = 1;
  logic act_grant = 0, cas_grant = 0, pre_grant = 0;
  logic free, act_req, cas_req, pre_req, cmd_write, left_open;
  logic [0:0] cmd_rank;
  logic [2:0] cmd_bank;
  logic [13:0] cmd_row;
  logic [9:0] cmd_col;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  bank_req_engine #(.RANKS(2), .BANK_W(3), .ROW_W(14), .COL_W(10),
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RTP(T_RTP), .T_RP(T_RP)) i_bank_req_engine (
    .clk, .rst_n, .req_valid, .req_rank, .req_bank, .req_row, .req_col, .req_write,
    .req_row_open, .same_bank_pending, .rank_inhibit, .col_inhibit, .cas_ok,
    .free, .act_req, .act_grant, .cas_req, .cas_grant, .pre_req, .pre_grant,
    .cmd_rank, .cmd_bank, .cmd_row, .cmd_col, .cmd_write, .left_open);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run(input bit inh, input bit keep, input bit wr, input int g,
                     input int rk, input int ih, input int ci, input int id);
    int tw, a0e, c0e, ce, p0e, fe;
    int a_first, c_first, p_first, f_at, ha, hc, hp, cas_n, fld_bad;
    logic [13:0] row;
    logic [9:0] col;
    logic [2:0] bank;
    tw = wr ? T_WR : T_RTP;
    if (inh) begin a0e = -1; c0e = ci; end
    else begin a0e = ih; c0e = (a0e + g + T_RCD > ci) ? a0e + g + T_RCD : ci; end
    ce = c0e + g;
    if (keep) begin p0e = -1; fe = ce + tw + 1; end
    else begin p0e = ce + tw; fe = p0e + g + T_RP + 1; end
    row = 14'(id * 97 + 5); col = 10'(id * 13 + 1); bank = 3'(id);
    a_first = -1; c_first = -1; p_first = -1; f_at = -1;
    ha = 0; hc = 0; hp = 0; cas_n = 0; fld_bad = 0;
    @(negedge clk);
    req_valid = 1; req_rank = 1'(rk); req_bank = bank; req_row = row; req_col = col;
    req_write = wr; req_row_open = inh; same_bank_pending = keep;
    @(negedge clk);
    req_valid = 0;
    for (int t = 0; t < 150 && f_at < 0; t++) begin
      rank_inhibit = (2'b01 << (1 - rk)) | ((t < ih) ? (2'b01 << rk) : 2'b00);
      col_inhibit = (t < ci) && (t % 2 == 1);
      cas_ok = !((t < ci) && (t % 2 == 0));
      if (t == 2) begin req_valid = 1; req_row = ~row; req_col = ~col; req_write = ~wr; end
      else req_valid = 0;
      #1;
      if (t == 0) chk("R1 busy after accept", free, 0);
      if (free) f_at = t;
      else if (cmd_row != row || cmd_col != col || cmd_bank != bank ||
               cmd_write != wr || cmd_rank != 1'(rk)) fld_bad++;
      act_grant = act_req && (ha >= g);
      if (act_req) begin if (a_first < 0) a_first = t; ha++; end
      cas_grant = cas_req && (hc >= g);
      if (cas_req) begin if (c_first < 0) c_first = t; hc++; end
      if (cas_grant) cas_n++;
      pre_grant = pre_req && (hp >= g);
      if (pre_req) begin if (p_first < 0) p_first = t; hp++; end
      @(negedge clk);
    end
    act_grant = 0; cas_grant = 0; pre_grant = 0; req_valid = 0;
    chk(inh ? "R6 no activate" : "R4 activate cycle", a_first, a0e);
    chk(inh ? "R6 column cycle" : "R3 column cycle", c_first, c0e);
    if (ci > 0) chk("R5 column held by bus/order", c_first >= ci, 1);
    chk("R10 one column grant", cas_n, 1);
    chk(keep ? "R7 precharge skipped" : "R8 precharge cycle", p_first, p0e);
    chk(keep ? "R7 release cycle" : "R9 release cycle", f_at, fe);
    chk("R7 left_open", left_open, keep);
    chk("R11 fields held, R1 busy request ignored", fld_bad, 0);
    if (!inh && !keep)
      chk("R2 order", (a_first < c_first) && (c_first < p_first) && (p_first < f_at), 1);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int id;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset free", free, 1);
    chk("R1 reset left_open", left_open, 0);
    chk("R1 reset no request", act_req | cas_req | pre_req, 0);
    id = 0;
    for (int inh = 0; inh < 2; inh++)
      for (int keep = 0; keep < 2; keep++)
        for (int wr = 0; wr < 2; wr++)
          for (int g = 0; g < 3; g++)
            for (int rk = 0; rk < 2; rk++) begin
              run(inh[0], keep[0], wr[0], g, rk, g + rk, (g == 2) ? 12 : 0, id);
              id++;
            end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule